// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a processor's status and program-counter registers and decides, each cycle, whether the interrupt level presented on its pending input is accepted. A level is accepted only when it outranks the level currently held in the status word. It must also lie within the configured number of levels, and at least one source in that level's source mask must be both raised and enabled. All qualification and routing is combinational. Every register update lands on one rising clock edge.

Two kinds of entry exist. Levels two and above vector straight to a per-level handler, and each saves the interrupted PC and status word in registers private to that level. Level one is turned into an exception instead. It becomes a user or kernel exception, or a double exception when the processor is already in exception mode, and it records a fixed cause code. Handler addresses can be moved at run time through a vector-base register. Outside an entry, the surrounding core keeps the PC, status word and vector base up to date through simple load ports.

Top module: `irq_entry_unit`

## Requirements
- R1: A pending level L is taken only when L is greater than the status interrupt-level field (status bits 3:0), L is at most the configured level count, and the AND of level L's source mask with the set and enable vectors is non-zero; pending level 0 is never taken.
- R2: When a level L of 2 or more is taken, the PC before the edge is stored in the saved-PC slot of level L, and the status word before the edge is stored in the saved-status slot of level L; all other slots keep their values.
- R3: On a level-2-or-above entry, the status word gets bits 3:0 replaced by L and bit 4 (exception mode) set; all other status bits keep their values.
- R4: On a level-1 entry the cause register becomes 4 and status bit 4 is set, while status bits 3:0 keep their values.
- R5: A level-1 entry with status bit 4 already set is a double exception (kind code 4). With the double-exception PC register present, the old PC goes there and the level-1 saved PC keeps its value. Without it, the old PC goes to the level-1 saved PC.
- R6: A level-1 entry with status bit 4 clear is a user exception (kind code 3) when status bit 5 is set, and a kernel exception (kind code 2) otherwise. The old PC is saved in the level-1 slot. A high-level entry reports kind code 1.
- R7: The new PC is a static vector: default base + 0x180 + (L-2)*0x40 for high level L, or base + 0x300 (kernel), + 0x340 (user) or + 0x3C0 (double). With relocation enabled it becomes static vector - default base + vector-base register; without relocation the static vector is used.
- R8: The entry strobe is high for exactly the cycle after each accepting edge. When no level qualifies, the PC, status, cause and saved registers do not change.
- R9: On an accepting edge, PC and status loads requested in the same cycle are ignored; outside an entry they are applied.
- R10: After reset the PC holds its reset parameter, the status word holds 0x1F, the vector base holds the default base, the strobe and kind are 0, and cause and saved registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pend_level | input | LW | Highest pending interrupt level (0 = none) |
| cfg_levels | input | LW | Number of levels configured |
| level_mask | input | NLVL*NSRC | Source mask per level, level L at bits (L-1)*NSRC upward |
| int_set | input | NSRC | Raised interrupt sources |
| int_enable | input | NSRC | Enabled interrupt sources |
| pc_load_en | input | 1 | Core writes the PC |
| pc_load_val | input | XW | PC value to write |
| ps_load_en | input | 1 | Core writes the status word |
| ps_load_val | input | 32 | Status value to write |
| vbase_load_en | input | 1 | Core writes the vector base |
| vbase_load_val | input | XW | Vector base value to write |
| pc_o | output | XW | Program counter |
| ps_o | output | 32 | Status word |
| vbase_o | output | XW | Vector-base register |
| epc_o | output | NLVL*XW | Saved PC per level, level L at bits (L-1)*XW upward |
| eps_o | output | (NLVL-1)*XW | Saved status per level 2 and up, level L at bits (L-2)*XW upward |
| cause_o | output | CAUSE_W | Exception cause register |
| depc_o | output | XW | Double-exception PC (0 when not present) |
| exc_taken | output | 1 | One-cycle entry strobe |
| entry_kind | output | 3 | Kind of last entry: 0 none, 1 high, 2 kernel, 3 user, 4 double |

## Verification
The properties assume that the configured level count never exceeds the number of levels the hardware was built with. They also assume that the core does not write the PC in a cycle the checker treats as idle, since a load changes the PC legitimately. The bench keeps cfg_levels at or below seven and drives loads only in dedicated setup cycles, except in the one scenario that deliberately collides a load with an entry. The pending level is held for exactly one edge and then returned to zero, so each scenario produces a single accepting edge whose result is sampled on the following falling edge. A second instance, built without a double-exception PC and without relocation, receives the same stimulus.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int PS_W        = 32;
    localparam int PS_LVL_W    = 4;
    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;
    localparam int LVL1_CAUSE  = 4;
    localparam logic [PS_W-1:0] PS_RESET = 32'h0000_001F;

    typedef enum logic [2:0] {
        EK_NONE   = 3'd0,
        EK_HIGH   = 3'd1,
        EK_KERNEL = 3'd2,
        EK_USER   = 3'd3,
        EK_DOUBLE = 3'd4
    } entry_kind_e;

    typedef struct packed {
        logic                take;
        entry_kind_e         kind;
        logic [PS_LVL_W-1:0] lvl;
    } entry_req_t;

    // Status word after a high-level entry: new level, exception mode set.
    function automatic logic [PS_W-1:0] ps_enter_high(
        input logic [PS_W-1:0]     ps,
        input logic [PS_LVL_W-1:0] lvl
    );
        logic [PS_W-1:0] r;
        r = ps;
        r[PS_LVL_W-1:0] = lvl;
        r[PS_EXCM_BIT]  = 1'b1;
        return r;
    endfunction

    // Status word after a level-1 entry: only exception mode changes.
    function automatic logic [PS_W-1:0] ps_enter_low(input logic [PS_W-1:0] ps);
        logic [PS_W-1:0] r;
        r = ps;
        r[PS_EXCM_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
    import irq_entry_pkg::*;
#(
    parameter int NLVL = 7,
    parameter int NSRC = 32,
    parameter int LW   = 3
) (
    input  logic [LW-1:0]        pend_level,
    input  logic [LW-1:0]        cfg_levels,
    input  logic [PS_LVL_W-1:0]  cur_level,
    input  logic [NLVL*NSRC-1:0] level_mask,
    input  logic [NSRC-1:0]      int_set,
    input  logic [NSRC-1:0]      int_enable,
    output logic                 take,
    output logic [PS_LVL_W-1:0]  lvl
);

    localparam int HITW = 2 ** LW;

    logic [NSRC-1:0] live_src;
    logic [HITW-1:0] lvl_hit;
    logic            in_range;
    logic            above_cur;

    assign live_src   = int_set & int_enable;
    assign lvl_hit[0] = 1'b0;

    for (genvar g = 1; g < HITW; g++) begin : g_hit
        if (g <= NLVL) begin : g_real
            assign lvl_hit[g] = |(level_mask[(g-1)*NSRC +: NSRC] & live_src);
        end else begin : g_pad
            assign lvl_hit[g] = 1'b0;
        end
    end

    always_comb begin
        lvl       = PS_LVL_W'(pend_level);
        in_range  = (pend_level != '0) && (pend_level <= cfg_levels);
        above_cur = lvl > cur_level;
        take      = in_range && above_cur && lvl_hit[pend_level];
    end

endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_entry_pkg::*;
#(
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic                take,
    input  logic [PS_LVL_W-1:0] lvl,
    input  logic                excm,
    input  logic                user_mode,
    output entry_req_t          req,
    output logic                save_depc
);

    always_comb begin
        req.take  = take;
        req.lvl   = lvl;
        req.kind  = EK_NONE;
        save_depc = 1'b0;
        if (take) begin
            if (lvl > PS_LVL_W'(1)) begin
                req.kind = EK_HIGH;
            end else if (excm) begin
                req.kind  = EK_DOUBLE;
                save_depc = HAS_DEPC;
            end else if (user_mode) begin
                req.kind = EK_USER;
            end else begin
                req.kind = EK_KERNEL;
            end
        end
    end

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irq_entry_pkg::*;
#(
    parameter int             XW          = 32,
    parameter bit             RELOC_EN    = 1'b1,
    parameter logic [XW-1:0]  VEC_BASE    = 32'h4000_0000,
    parameter logic [XW-1:0]  HIGH_OFS    = 32'h0000_0180,
    parameter logic [XW-1:0]  HIGH_STRIDE = 32'h0000_0040,
    parameter logic [XW-1:0]  KERNEL_OFS  = 32'h0000_0300,
    parameter logic [XW-1:0]  USER_OFS    = 32'h0000_0340,
    parameter logic [XW-1:0]  DOUBLE_OFS  = 32'h0000_03C0
) (
    input  entry_kind_e         kind,
    input  logic [PS_LVL_W-1:0] lvl,
    input  logic [XW-1:0]       vbase,
    output logic [XW-1:0]       target
);

    logic [XW-1:0] static_vec;
    logic [XW-1:0] lvl_step;

    always_comb begin
        lvl_step = (lvl >= PS_LVL_W'(2)) ? XW'(lvl - PS_LVL_W'(2)) : '0;
        unique case (kind)
            EK_HIGH:   static_vec = VEC_BASE + HIGH_OFS + lvl_step * HIGH_STRIDE;
            EK_KERNEL: static_vec = VEC_BASE + KERNEL_OFS;
            EK_USER:   static_vec = VEC_BASE + USER_OFS;
            EK_DOUBLE: static_vec = VEC_BASE + DOUBLE_OFS;
            default:   static_vec = VEC_BASE;
        endcase
    end

    if (RELOC_EN) begin : g_reloc
        assign target = static_vec - VEC_BASE + vbase;
    end else begin : g_fixed
        logic [XW-1:0] vbase_unused;
        assign vbase_unused = vbase;
        assign target       = static_vec;
    end

endmodule

// File: rtl/irq_state_file.sv
module irq_state_file
    import irq_entry_pkg::*;
#(
    parameter int            XW       = 32,
    parameter int            NLVL     = 7,
    parameter int            CAUSE_W  = 6,
    parameter bit            HAS_DEPC = 1'b1,
    parameter logic [XW-1:0] RESET_PC = 32'h5000_0000,
    parameter logic [XW-1:0] VEC_BASE = 32'h4000_0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  entry_req_t             req,
    input  logic                   save_depc,
    input  logic [XW-1:0]          target,
    input  logic                   pc_load_en,
    input  logic [XW-1:0]          pc_load_val,
    input  logic                   ps_load_en,
    input  logic [PS_W-1:0]        ps_load_val,
    input  logic                   vbase_load_en,
    input  logic [XW-1:0]          vbase_load_val,
    output logic [XW-1:0]          pc_o,
    output logic [PS_W-1:0]        ps_o,
    output logic [XW-1:0]          vbase_o,
    output logic [NLVL*XW-1:0]     epc_o,
    output logic [(NLVL-1)*XW-1:0] eps_o,
    output logic [CAUSE_W-1:0]     cause_o,
    output logic [XW-1:0]          depc_o,
    output logic                   exc_taken,
    output logic [2:0]             entry_kind
);

    logic [XW-1:0]      pc_q;
    logic [PS_W-1:0]    ps_q;
    logic [XW-1:0]      vbase_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               taken_q;
    entry_kind_e        kind_q;
    logic               is_high;

    assign is_high = req.take && (req.kind == EK_HIGH);

    // PC, status, cause: an entry outranks the core's own loads.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RESET_PC;
            ps_q    <= PS_RESET;
            cause_q <= '0;
            taken_q <= 1'b0;
            kind_q  <= EK_NONE;
        end else begin
            taken_q <= req.take;
            if (req.take) begin
                kind_q <= req.kind;
                pc_q   <= target;
                if (is_high) begin
                    ps_q <= ps_enter_high(ps_q, req.lvl);
                end else begin
                    ps_q    <= ps_enter_low(ps_q);
                    cause_q <= CAUSE_W'(LVL1_CAUSE);
                end
            end else begin
                if (pc_load_en) pc_q <= pc_load_val;
                if (ps_load_en) ps_q <= ps_load_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                vbase_q <= VEC_BASE;
        else if (vbase_load_en) vbase_q <= vbase_load_val;
    end

    // Saved PC, one register per level.
    for (genvar g = 1; g <= NLVL; g++) begin : g_epc
        logic [XW-1:0] epc_r;
        logic          wr;
        if (g == 1) begin : g_l1
            assign wr = req.take && !is_high && !save_depc;
        end else begin : g_hi
            assign wr = is_high && (req.lvl == PS_LVL_W'(g));
        end
        always_ff @(posedge clk) begin
            if (rst)     epc_r <= '0;
            else if (wr) epc_r <= pc_q;
        end
        assign epc_o[(g-1)*XW +: XW] = epc_r;
    end

    // Saved status, one register per level from 2 upward.
    for (genvar g = 2; g <= NLVL; g++) begin : g_eps
        logic [PS_W-1:0] eps_r;
        logic            wr;
        assign wr = is_high && (req.lvl == PS_LVL_W'(g));
        always_ff @(posedge clk) begin
            if (rst)     eps_r <= '0;
            else if (wr) eps_r <= ps_q;
        end
        assign eps_o[(g-2)*XW +: XW] = XW'(eps_r);
    end

    if (HAS_DEPC) begin : g_depc
        logic [XW-1:0] depc_r;
        always_ff @(posedge clk) begin
            if (rst)                      depc_r <= '0;
            else if (req.take && save_depc) depc_r <= pc_q;
        end
        assign depc_o = depc_r;
    end else begin : g_no_depc
        assign depc_o = '0;
    end

    assign pc_o       = pc_q;
    assign ps_o       = ps_q;
    assign vbase_o    = vbase_q;
    assign cause_o    = cause_q;
    assign exc_taken  = taken_q;
    assign entry_kind = kind_q;

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter int            NLVL        = 7,
    parameter int            NSRC        = 32,
    parameter int            XW          = 32,
    parameter int            CAUSE_W     = 6,
    parameter bit            HAS_DEPC    = 1'b1,
    parameter bit            RELOC_EN    = 1'b1,
    parameter logic [XW-1:0] RESET_PC    = 32'h5000_0000,
    parameter logic [XW-1:0] VEC_BASE    = 32'h4000_0000,
    parameter logic [XW-1:0] HIGH_OFS    = 32'h0000_0180,
    parameter logic [XW-1:0] HIGH_STRIDE = 32'h0000_0040,
    parameter logic [XW-1:0] KERNEL_OFS  = 32'h0000_0300,
    parameter logic [XW-1:0] USER_OFS    = 32'h0000_0340,
    parameter logic [XW-1:0] DOUBLE_OFS  = 32'h0000_03C0,
    localparam int           LW          = $clog2(NLVL + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LW-1:0]          pend_level,
    input  logic [LW-1:0]          cfg_levels,
    input  logic [NLVL*NSRC-1:0]   level_mask,
    input  logic [NSRC-1:0]        int_set,
    input  logic [NSRC-1:0]        int_enable,
    input  logic                   pc_load_en,
    input  logic [XW-1:0]          pc_load_val,
    input  logic                   ps_load_en,
    input  logic [31:0]            ps_load_val,
    input  logic                   vbase_load_en,
    input  logic [XW-1:0]          vbase_load_val,
    output logic [XW-1:0]          pc_o,
    output logic [31:0]            ps_o,
    output logic [XW-1:0]          vbase_o,
    output logic [NLVL*XW-1:0]     epc_o,
    output logic [(NLVL-1)*XW-1:0] eps_o,
    output logic [CAUSE_W-1:0]     cause_o,
    output logic [XW-1:0]          depc_o,
    output logic                   exc_taken,
    output logic [2:0]             entry_kind
);

    logic                take;
    logic [PS_LVL_W-1:0] lvl;
    entry_req_t          req;
    logic                save_depc;
    logic [XW-1:0]       target;

    irq_level_gate #(.NLVL(NLVL), .NSRC(NSRC), .LW(LW)) u_gate (
        .pend_level (pend_level),
        .cfg_levels (cfg_levels),
        .cur_level  (ps_o[PS_LVL_W-1:0]),
        .level_mask (level_mask),
        .int_set    (int_set),
        .int_enable (int_enable),
        .take       (take),
        .lvl        (lvl)
    );

    irq_route #(.HAS_DEPC(HAS_DEPC)) u_route (
        .take      (take),
        .lvl       (lvl),
        .excm      (ps_o[PS_EXCM_BIT]),
        .user_mode (ps_o[PS_UM_BIT]),
        .req       (req),
        .save_depc (save_depc)
    );

    irq_vector_gen #(
        .XW(XW), .RELOC_EN(RELOC_EN), .VEC_BASE(VEC_BASE),
        .HIGH_OFS(HIGH_OFS), .HIGH_STRIDE(HIGH_STRIDE),
        .KERNEL_OFS(KERNEL_OFS), .USER_OFS(USER_OFS), .DOUBLE_OFS(DOUBLE_OFS)
    ) u_vec (
        .kind   (req.kind),
        .lvl    (req.lvl),
        .vbase  (vbase_o),
        .target (target)
    );

    irq_state_file #(
        .XW(XW), .NLVL(NLVL), .CAUSE_W(CAUSE_W), .HAS_DEPC(HAS_DEPC),
        .RESET_PC(RESET_PC), .VEC_BASE(VEC_BASE)
    ) u_state (
        .clk            (clk),
        .rst            (rst),
        .req            (req),
        .save_depc      (save_depc),
        .target         (target),
        .pc_load_en     (pc_load_en),
        .pc_load_val    (pc_load_val),
        .ps_load_en     (ps_load_en),
        .ps_load_val    (ps_load_val),
        .vbase_load_en  (vbase_load_en),
        .vbase_load_val (vbase_load_val),
        .pc_o           (pc_o),
        .ps_o           (ps_o),
        .vbase_o        (vbase_o),
        .epc_o          (epc_o),
        .eps_o          (eps_o),
        .cause_o        (cause_o),
        .depc_o         (depc_o),
        .exc_taken      (exc_taken),
        .entry_kind     (entry_kind)
    );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int LW      = 3,
    parameter int XW      = 32,
    parameter int CAUSE_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [LW-1:0]      pend_level,
    input logic [LW-1:0]      cfg_levels,
    input logic               pc_load_en,
    input logic [XW-1:0]      pc_o,
    input logic [31:0]        ps_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic               exc_taken,
    input logic [2:0]         entry_kind
);

    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    AST_TAKE_ABOVE_CUR: assert property (@(posedge clk) disable iff (rst)
        armed_q && exc_taken |-> $past(pend_level) > $past(ps_o[3:0])); // R1

    AST_TAKE_WITHIN_CFG: assert property (@(posedge clk) disable iff (rst)
        armed_q && exc_taken |-> ($past(pend_level) <= $past(cfg_levels)) && ($past(pend_level) != '0)); // R1

    AST_HIGH_STATUS: assert property (@(posedge clk) disable iff (rst)
        armed_q && exc_taken && ($past(pend_level) > 1) |-> (ps_o[3:0] == 4'($past(pend_level))) && ps_o[4]); // R3

    AST_LOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
        armed_q && exc_taken && ($past(pend_level) == 1) |-> (cause_o == CAUSE_W'(4)) && ps_o[4] && $stable(ps_o[3:0])); // R4

    AST_DOUBLE_KIND: assert property (@(posedge clk) disable iff (rst)
        armed_q && exc_taken && ($past(pend_level) == 1) && $past(ps_o[4]) |-> entry_kind == 3'd4); // R5

    AST_USER_KERNEL: assert property (@(posedge clk) disable iff (rst)
        armed_q && exc_taken && ($past(pend_level) == 1) && !$past(ps_o[4])
        |-> entry_kind == ($past(ps_o[5]) ? 3'd3 : 3'd2)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        armed_q && !exc_taken && !$past(pc_load_en) |-> $stable(pc_o)); // R8

endmodule

bind irq_entry_unit irq_entry_chk #(.LW(LW), .XW(XW), .CAUSE_W(CAUSE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pend_level (pend_level),
    .cfg_levels (cfg_levels),
    .pc_load_en (pc_load_en),
    .pc_o       (pc_o),
    .ps_o       (ps_o),
    .cause_o    (cause_o),
    .exc_taken  (exc_taken),
    .entry_kind (entry_kind)
);

// File: tb/sim_irq_entry_unit.sv
module sim_irq_entry_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NLVL = 7;
    localparam int NSRC = 32;
    localparam int XW   = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [2:0]           pend_level = '0;
    logic [2:0]           cfg_levels = 3'd7;
    logic [NLVL*NSRC-1:0] level_mask;
    logic [NSRC-1:0]      int_set = '0;
    logic [NSRC-1:0]      int_enable = '0;
    logic                 pc_load_en = 1'b0;
    logic [XW-1:0]        pc_load_val = '0;
    logic                 ps_load_en = 1'b0;
    logic [31:0]          ps_load_val = '0;
    logic                 vbase_load_en = 1'b0;
    logic [XW-1:0]        vbase_load_val = '0;

    logic [XW-1:0]          pc0, pc1, vb0, vb1, depc0, depc1;
    logic [31:0]            ps0, ps1;
    logic [NLVL*XW-1:0]     epc0, epc1;
    logic [(NLVL-1)*XW-1:0] eps0, eps1;
    logic [5:0]             cause0, cause1;
    logic                   tk0, tk1;
    logic [2:0]             kd0, kd1;

    irq_entry_unit u0 (
        .clk(clk), .rst(rst), .pend_level(pend_level), .cfg_levels(cfg_levels),
        .level_mask(level_mask), .int_set(int_set), .int_enable(int_enable),
        .pc_load_en(pc_load_en), .pc_load_val(pc_load_val),
        .ps_load_en(ps_load_en), .ps_load_val(ps_load_val),
        .vbase_load_en(vbase_load_en), .vbase_load_val(vbase_load_val),
        .pc_o(pc0), .ps_o(ps0), .vbase_o(vb0), .epc_o(epc0), .eps_o(eps0),
        .cause_o(cause0), .depc_o(depc0), .exc_taken(tk0), .entry_kind(kd0)
    );

    irq_entry_unit #(.HAS_DEPC(1'b0), .RELOC_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .pend_level(pend_level), .cfg_levels(cfg_levels),
        .level_mask(level_mask), .int_set(int_set), .int_enable(int_enable),
        .pc_load_en(pc_load_en), .pc_load_val(pc_load_val),
        .ps_load_en(ps_load_en), .ps_load_val(ps_load_val),
        .vbase_load_en(vbase_load_en), .vbase_load_val(vbase_load_val),
        .pc_o(pc1), .ps_o(ps1), .vbase_o(vb1), .epc_o(epc1), .eps_o(eps1),
        .cause_o(cause1), .depc_o(depc1), .exc_taken(tk1), .entry_kind(kd1)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Level L's mask selects source bit L only.
    always_comb begin
        level_mask = '0;
        for (int l = 1; l <= NLVL; l++) level_mask[(l-1)*NSRC + l] = 1'b1;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] epc_at(input logic [NLVL*XW-1:0] v, input int l);
        return v[(l-1)*XW +: XW];
    endfunction

    function automatic logic [31:0] eps_at(input logic [(NLVL-1)*XW-1:0] v, input int l);
        return v[(l-2)*XW +: XW];
    endfunction

    // Setup cycle: core loads PC and status.
    task automatic load_core(input logic [31:0] pc, input logic [31:0] ps);
        @(negedge clk);
        pc_load_en = 1'b1; pc_load_val = pc;
        ps_load_en = 1'b1; ps_load_val = ps;
        @(negedge clk);
        pc_load_en = 1'b0; ps_load_en = 1'b0;
    endtask

    // Present a level for one edge, then withdraw it; sample after the edge.
    task automatic fire(input int lvl, input logic [31:0] src);
        @(negedge clk);
        pend_level = 3'(lvl);
        int_set = src; int_enable = src;
        @(negedge clk);
        pend_level = '0;
    endtask

    task automatic t_reset();
        check("R10", "pc", pc0, 32'h5000_0000);
        check("R10", "ps", ps0, 32'h1F);
        check("R10", "vbase", vb0, 32'h4000_0000);
        check("R10", "cause", 32'(cause0), 0);
        check("R10", "taken", 32'(tk0), 0);
        check("R10", "epc1", epc_at(epc0, 1), 0);
    endtask

    task automatic t_high_entry();
        load_core(32'h1000, 32'h0000_0001);
        fire(3, 32'h8);
        check("R8", "strobe", 32'(tk0), 1);
        check("R6", "kind", 32'(kd0), 1);
        check("R7", "pc", pc0, 32'h4000_01C0);
        check("R2", "epc3", epc_at(epc0, 3), 32'h1000);
        check("R2", "eps3", eps_at(eps0, 3), 32'h1);
        check("R2", "eps2 untouched", eps_at(eps0, 2), 0);
        check("R3", "ps", ps0, 32'h13);
        @(negedge clk);
        check("R8", "strobe drop", 32'(tk0), 0);
    endtask

    task automatic t_not_taken();
        // equal to current level 3
        fire(3, 32'h8);
        check("R1", "equal level strobe", 32'(tk0), 0);
        check("R8", "equal level pc", pc0, 32'h4000_01C0);
        // above configured count
        cfg_levels = 3'd4;
        fire(5, 32'h20);
        check("R1", "over cfg strobe", 32'(tk0), 0);
        check("R8", "over cfg ps", ps0, 32'h13);
        cfg_levels = 3'd7;
        // raised but not enabled
        @(negedge clk);
        pend_level = 3'd4; int_set = 32'h10; int_enable = 32'h0;
        @(negedge clk);
        pend_level = '0;
        check("R1", "disabled strobe", 32'(tk0), 0);
        check("R8", "disabled epc4", epc_at(epc0, 4), 0);
        // enabled source outside the level's mask
        fire(4, 32'h8);
        check("R1", "wrong source strobe", 32'(tk0), 0);
    endtask

    task automatic t_kernel_then_double();
        load_core(32'h2000, 32'h0);
        fire(1, 32'h2);
        check("R6", "kernel kind", 32'(kd0), 2);
        check("R7", "kernel pc", pc0, 32'h4000_0300);
        check("R6", "kernel epc1", epc_at(epc0, 1), 32'h2000);
        check("R4", "cause", 32'(cause0), 4);
        check("R4", "ps", ps0, 32'h10);
        fire(1, 32'h2);
        check("R5", "double kind", 32'(kd0), 4);
        check("R7", "double pc", pc0, 32'h4000_03C0);
        check("R5", "depc", depc0, 32'h4000_0300);
        check("R5", "epc1 kept", epc_at(epc0, 1), 32'h2000);
        check("R5", "no-depc epc1", epc_at(epc1, 1), 32'h4000_0300);
        check("R5", "no-depc depc", depc1, 0);
    endtask

    task automatic t_user();
        load_core(32'h3000, 32'h20);
        fire(1, 32'h2);
        check("R6", "user kind", 32'(kd0), 3);
        check("R7", "user pc", pc0, 32'h4000_0340);
        check("R6", "user epc1", epc_at(epc0, 1), 32'h3000);
        check("R4", "user ps", ps0, 32'h30);
    endtask

    task automatic t_load_collision();
        load_core(32'h4000, 32'h0);
        @(negedge clk);
        pend_level = 3'd2; int_set = 32'h4; int_enable = 32'h4;
        pc_load_en = 1'b1; pc_load_val = 32'hDEAD_0000;
        ps_load_en = 1'b1; ps_load_val = 32'h5;
        @(negedge clk);
        pend_level = '0; pc_load_en = 1'b0; ps_load_en = 1'b0;
        check("R9", "pc wins", pc0, 32'h4000_0180);
        check("R9", "ps wins", ps0, 32'h12);
        check("R2", "epc2", epc_at(epc0, 2), 32'h4000);
    endtask

    task automatic t_reloc();
        load_core(32'h5000, 32'h0);
        @(negedge clk);
        vbase_load_en = 1'b1; vbase_load_val = 32'h8000_0000;
        @(negedge clk);
        vbase_load_en = 1'b0;
        fire(2, 32'h4);
        check("R7", "reloc pc", pc0, 32'h8000_0180);
        check("R7", "fixed pc", pc1, 32'h4000_0180);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_high_entry();
        t_not_taken();
        t_kernel_then_double();
        t_user();
        t_load_collision();
        t_reloc();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule